// File: doc/BRIEF.md
# Secondary Interrupt Aggregator with Line Forwarding

This block gathers 32 level-sensitive interrupt sources into one combined request for a primary interrupt controller. Every source has its own enable bit. The combined request is high while any enabled source is high. A separate forwarding enable lets selected lines in the range 21 to 30 bypass the combine stage. Each forwarded line then drives the matching primary-controller input one-to-one. Line 0 can also be raised from software, so code can post an interrupt through the same path.

Software reaches the block over a plain 32-bit register port: a byte address, read and write strobes, write data and read data. The register window is 4 KB. Bits [11:2] of the address select a word, and bits [1:0] are ignored. The source vector is registered once per clock. All outputs and all read views come from that registered copy, with the software bit merged into line 0.

Top module: `irq_aggregator`

## Requirements
- R1: `irq_out` is high in a cycle exactly when the bitwise AND of the current level vector and the enable register is nonzero. The level vector is the registered sources, with bit 0 ORed with the software bit.
- R2: A write to word 2 (byte 0x08) sets each enable bit whose write-data bit is 1. A write to word 3 (byte 0x0C) clears each enable bit whose write-data bit is 1. Bits written as 0 keep their value. A read of word 2 returns the enable register.
- R3: `src_irq` is captured on every rising clock edge and the block uses only that captured copy. A read of word 1 returns the level vector. A read of word 0 returns the level vector ANDed with the enables.
- R4: A write to word 8 (byte 0x20) sets forwarding-enable bits, but only bits 21 to 30 (mask 0x7FE00000). A write to word 9 (byte 0x24) clears each forwarding-enable bit whose write-data bit is 1. A read of word 8 returns the forwarding-enable register.
- R5: Bit i of `fwd_irq` equals level bit i when forwarding-enable bit i is set, and is 0 otherwise. Bits outside 21 to 30 are therefore always 0.
- R6: A nonzero write to word 4 (byte 0x10) sets the software bit. A nonzero write to word 5 (byte 0x14) clears it. A zero write to either word has no effect. A read of word 4 returns level bit 0 in bit 0 and zeros above.
- R7: A read of any word other than 0, 1, 2, 4 and 8 returns 0. This includes the write-only words 3, 5 and 9. A write to any word other than 2, 3, 4, 5, 8 and 9 changes no state.
- R8: While `rst_n` is low, and on the first cycle after it is released, the enables, forwarding enables, software bit and captured sources are 0. `irq_out` and `fwd_irq` are then 0.
- R9: `bus_rdata` is 0 in every cycle where `bus_rd` is low.
- R10: A register write or a source change is visible on `irq_out`, `fwd_irq` and the read views in the cycle right after the rising edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address within the register window |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational while `bus_rd` is high |
| src_irq | input | 32 | Raw level-sensitive interrupt sources |
| irq_out | output | 1 | Combined request to the primary controller |
| fwd_irq | output | 32 | Per-line forwarded requests to the primary controller |

## Verification
Nothing is pipelined beyond the source capture. A wrong enable bit, forwarding bit or software bit therefore shows on `irq_out` or `fwd_irq` in the first cycle after the offending edge. It also shows on the next read of words 0, 1, 2, 4 or 8. The bench's reference model recomputes every output and every read after each edge. It flags a divergence within one cycle. Random source patterns keep lines toggling, so a stuck or misrouted forwarding bit does not stay hidden.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int W     = 32,
  parameter int AW    = 12,
  parameter int PT_LO = 21,
  parameter int PT_HI = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  src_irq,
  output logic          irq_out,
  output logic [W-1:0]  fwd_irq
);
  localparam int OW = AW - 2;
  localparam logic [W-1:0] PT_MASK = ({W{1'b1}} >> (W - 1 - PT_HI)) & ({W{1'b1}} << PT_LO);
  localparam logic [OW-1:0] O_STAT = OW'(0), O_RAW = OW'(1), O_EN = OW'(2), O_ENCLR = OW'(3),
                            O_SW = OW'(4), O_SWCLR = OW'(5), O_PT = OW'(8), O_PTCLR = OW'(9);

  logic [W-1:0]  raw_q, en_q, pt_q, lvl;
  logic          sw_q;
  logic [OW-1:0] woff;

  assign woff = bus_addr[AW-1:2];
  assign lvl  = raw_q | {{(W-1){1'b0}}, sw_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
      en_q  <= '0;
      pt_q  <= '0;
      sw_q  <= 1'b0;
    end else begin
      raw_q <= src_irq;
      if (bus_wr) begin
        case (woff)
          O_EN:    en_q <= en_q | bus_wdata;
          O_ENCLR: en_q <= en_q & ~bus_wdata;
          O_SW:    if (|bus_wdata) sw_q <= 1'b1;
          O_SWCLR: if (|bus_wdata) sw_q <= 1'b0;
          O_PT:    pt_q <= pt_q | (bus_wdata & PT_MASK);
          O_PTCLR: pt_q <= pt_q & ~bus_wdata;
          default: ;
        endcase
      end
    end
  end

  assign irq_out = |(lvl & en_q);
  assign fwd_irq = lvl & pt_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (woff)
        O_STAT:  bus_rdata = lvl & en_q;
        O_RAW:   bus_rdata = lvl;
        O_EN:    bus_rdata = en_q;
        O_SW:    bus_rdata = {{(W-1){1'b0}}, lvl[0]};
        O_PT:    bus_rdata = pt_q;
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter int W     = 32,
  parameter int AW    = 12,
  parameter int PT_LO = 21,
  parameter int PT_HI = 30
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [W-1:0]  bus_wdata,
  input logic [W-1:0]  bus_rdata,
  input logic [W-1:0]  src_irq,
  input logic          irq_out,
  input logic [W-1:0]  fwd_irq
);
  localparam logic [W-1:0] PT_MASK = ({W{1'b1}} >> (W - 1 - PT_HI)) & ({W{1'b1}} << PT_LO);
  logic [AW-3:0] woff;
  logic          mapped_rd;
  assign woff = bus_addr[AW-1:2];
  assign mapped_rd = (woff == 0) || (woff == 1) || (woff == 2) || (woff == 4) || (woff == 8);

  // R5
  fwd_outside_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_irq & ~PT_MASK) == '0);
  // R5
  fwd_follows_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_irq & ~$past(src_irq)) == '0);
  // R2
  enclr_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && woff == 3 && bus_wdata == {W{1'b1}}) |=> !irq_out);
  // R4
  ptclr_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && woff == 9 && bus_wdata == {W{1'b1}}) |=> fwd_irq == '0);
  // R7
  unmapped_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !mapped_rd) |-> bus_rdata == '0);
  // R9
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == '0);

  always_ff @(posedge clk) begin
    // R8
    if (!rst_n) reset_quiet_chk: assert (!irq_out && fwd_irq == '0);
  end
endmodule

bind irq_aggregator irq_aggregator_chk #(.W(W), .AW(AW), .PT_LO(PT_LO), .PT_HI(PT_HI)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_irq(src_irq),
  .irq_out(irq_out), .fwd_irq(fwd_irq)
);

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0, src_irq = '0;
  logic [31:0] bus_rdata, fwd_irq;
  logic        irq_out;

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_raw = '0, m_en = '0, m_pt = '0;
  logic        m_sw = 1'b0;

  always #2 clk = ~clk;

  irq_aggregator u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_irq(src_irq),
    .irq_out(irq_out), .fwd_irq(fwd_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] lvl_m();
    return m_raw | {31'b0, m_sw};
  endfunction

  function automatic logic [31:0] rd_m(input int off);
    case (off)
      0: return lvl_m() & m_en;
      1: return lvl_m();
      2: return m_en;
      4: return {31'b0, lvl_m()[0]};
      8: return m_pt;
      default: return '0;
    endcase
  endfunction

  task automatic tick(input int off, input bit rd, input bit wr, input logic [31:0] wd,
                      input logic [31:0] s, input string req);
    bus_addr = 12'(off * 4); bus_rd = rd; bus_wr = wr; bus_wdata = wd; src_irq = s;
    #1;
    chk({"R1/R10 ", req}, {31'b0, irq_out}, {31'b0, |(lvl_m() & m_en)});
    chk({"R5/R10 ", req}, fwd_irq, lvl_m() & m_pt);
    if (rd) chk({"R3/R7 read ", req}, bus_rdata, rd_m(off));
    else    chk({"R9 ", req}, bus_rdata, 32'h0);
    @(posedge clk);
    m_raw = s;
    if (wr) case (off)
      2: m_en = m_en | wd;
      3: m_en = m_en & ~wd;
      4: if (wd != 0) m_sw = 1'b1;
      5: if (wd != 0) m_sw = 1'b0;
      8: m_pt = m_pt | (wd & 32'h7FE0_0000);
      9: m_pt = m_pt & ~wd;
      default: ;
    endcase
    @(negedge clk);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    src_irq = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    #1;
    chk("R8 reset irq", {31'b0, irq_out}, 32'h0);
    chk("R8 reset fwd", fwd_irq, 32'h0);
    src_irq = '0;
    @(negedge clk);
    rst_n = 1'b1;
    tick(2, 1, 0, 0, 32'h0, "R8 enables after reset");
    tick(8, 1, 0, 0, 32'h0, "R8 forwarding after reset");
    tick(1, 1, 0, 0, 32'h8000_0010, "R3 raw capture");
    tick(1, 1, 0, 0, 32'h8000_0010, "R3 raw read");
    tick(2, 0, 1, 32'h0000_00F0, 32'h8000_0010, "R2 set");
    tick(0, 1, 0, 0, 32'h8000_0010, "R1 masked status");
    tick(3, 0, 1, 32'h0000_0010, 32'h8000_0010, "R2 clear one bit");
    tick(2, 1, 0, 0, 32'h0000_00E0, "R2 enable read");
    tick(8, 0, 1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, "R4 set masked");
    tick(8, 1, 0, 0, 32'h4020_0000, "R4 read");
    tick(9, 0, 1, 32'h0020_0000, 32'h4020_0000, "R4 clear bit 21");
    tick(1, 1, 0, 0, 32'h0, "R5 forwarding drops");
    tick(4, 0, 1, 32'h0, 32'h0, "R6 zero set write");
    tick(4, 1, 0, 0, 32'h0, "R6 soft read idle");
    tick(2, 0, 1, 32'h1, 32'h0, "R6 enable line 0");
    tick(4, 0, 1, 32'h0000_0100, 32'h0, "R6 nonzero set");
    tick(4, 1, 0, 0, 32'h0, "R6 soft read set");
    tick(5, 0, 1, 32'h0, 32'h0, "R6 zero clear write");
    tick(5, 0, 1, 32'h8000_0000, 32'h0, "R6 nonzero clear");
    tick(4, 1, 0, 0, 32'h0, "R6 soft read cleared");
    for (int o = 0; o < 16; o++) tick(o, 0, 1, 32'hFFFF_FFFF, 32'hA5A5_5A5A, "R7 write sweep");
    for (int o = 0; o < 16; o++) tick(o, 1, 0, 0, 32'h5A5A_A5A5, "R7 read sweep");
    for (int i = 0; i < 3000; i++) begin
      int o = $urandom_range(0, 11);
      logic [31:0] wd = ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF : $urandom;
      tick(o, $urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0, wd, $urandom, "random");
    end
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule